// File: doc/BRIEF.md
# Serial-Loaded Wiper Position Controller

This block is the digital core of a programmable resistor ladder. A three-wire serial port, made up of an active-low select, a serial clock and a data line, feeds a shift register. When the select line is released, the word in the shift register is copied into a wiper latch. The latch code is decoded into a one-hot tap-select bus and two terminal switch enables. The block drives ideal switch-enable signals only. It holds no analog behaviour and checks no electrical timing.

A parameter picks one of two ladders. The first has 256 positions and takes an 8-bit word. The second has 33 positions and takes a 6-bit word, and any code above its top tap selects that top tap. After reset the latch holds the midscale code. An active-low shutdown input acts without waiting for a clock. While it is low, the A-side switch opens and the wiper is tied to the B end. The latch keeps its value through shutdown and can still be written over the serial port.

The serial clock, select and data lines are asynchronous to the system clock. Each passes through a two-flop synchroniser, and the block acts on edges of the synchronised copies.

Top module: `wiper_pos_ctrl`

## Requirements
- R1: After reset, the 256-position variant selects tap 128 (code 0x80), with the A-side switch enabled and the B short disabled.
- R2: While the select is low, every rising serial clock edge shifts one data bit into the shift register, most significant bit first. A rising edge of the select copies the shift register into the latch.
- R3: Serial clock edges that arrive while the select is high change neither the latch nor the shift register.
- R4: If a frame is longer or shorter than the word width, the latch takes the last word-width bits shifted in. For a short frame, the missing upper bits come from the bits held before the frame.
- R5: Exactly one tap-select bit is high at all times. Code 0 selects tap 0, the B end, and each code step moves the selection up one tap.
- R6: In the 33-position variant, latch codes 33 to 63 all select tap 32.
- R7: While shutdown is low, with no clock edge needed, the A-side switch enable is 0, the B short enable is 1, and only tap 0 is selected, whatever the latch code is.
- R8: The latch value survives shutdown. On release, the tap given by that value is selected again.
- R9: Frames sent during shutdown load the latch. The new code shows on the tap bus once shutdown is released.
- R10: After reset, the 33-position variant selects tap 16 (code 0x10).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, asynchronous, rising edge active |
| csN | input | 1 | Active-low frame select; its rising edge loads the latch |
| sdi | input | 1 | Serial data, most significant bit first |
| shdnN | input | 1 | Active-low asynchronous shutdown |
| tapSel | output | NUM_TAPS | One-hot tap select (256 or 33 bits) |
| aSwitchEn | output | 1 | Enable for the A-terminal switch |
| wiperShortB | output | 1 | Enable for the wiper-to-B short |

## Verification
The assertions assume the serial lines change slowly compared with the system clock. Each level of sclk and csN must last at least a few system cycles. sdi must be steady at each sampled sclk rise. csN must never rise in the same synchronised cycle as an sclk rise. The bench holds every serial level for four system cycles, settles the select before the first bit and after the last, and draws random data, frame lengths and shutdown toggles only inside that pacing. One shared stream drives both variants at once, so the same frames also exercise the saturation range of the 33-position variant.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

  typedef struct packed {
    logic shiftEn;
    logic loadEn;
    logic serialBit;
  } wiperStrobe_t;

  function automatic int wordBits(bit smallLadder);
    return smallLadder ? 6 : 8;
  endfunction

  function automatic int tapCount(bit smallLadder);
    return smallLadder ? 33 : 256;
  endfunction

  function automatic int midCode(bit smallLadder);
    return smallLadder ? 16 : 128;
  endfunction

endpackage

// File: rtl/wiper_sync.sv
module wiper_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= RST_VAL;
      dout   <= RST_VAL;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/wiper_ctrl.sv
module wiper_ctrl
  import wiper_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         sclk,
  input  logic         csN,
  input  logic         sdi,
  output wiperStrobe_t strobe
);
  logic [2:0] syncd;
  logic       sclkPrev;
  logic       csPrev;

  // bit order: sclk, csN, sdi; select idles high
  wiper_sync #(.W(3), .RST_VAL(3'b010)) uSync (
    .clk  (clk),
    .rstN (rstN),
    .din  ({sclk, csN, sdi}),
    .dout (syncd)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      csPrev   <= 1'b1;
    end else begin
      sclkPrev <= syncd[2];
      csPrev   <= syncd[1];
    end
  end

  always_comb begin
    strobe.shiftEn   = syncd[2] & ~sclkPrev & ~syncd[1];
    strobe.loadEn    = syncd[1] & ~csPrev;
    strobe.serialBit = syncd[0];
  end
endmodule

// File: rtl/wiper_datapath.sv
module wiper_datapath
  import wiper_pkg::*;
#(
  parameter bit SMALL_LADDER = 1'b0,
  localparam int WORD_W   = wordBits(SMALL_LADDER),
  localparam int NUM_TAPS = tapCount(SMALL_LADDER)
) (
  input  logic                clk,
  input  logic                rstN,
  input  wiperStrobe_t        strobe,
  input  logic                shdnN,
  output logic [WORD_W-1:0]   latchCode,
  output logic [NUM_TAPS-1:0] tapSel,
  output logic                aSwitchEn,
  output logic                wiperShortB
);
  localparam int TOP_TAP = NUM_TAPS - 1;
  localparam logic [WORD_W-1:0] MID = WORD_W'(midCode(SMALL_LADDER));

  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] effCode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      latchCode <= MID;
    end else begin
      if (strobe.shiftEn) shiftReg <= {shiftReg[WORD_W-2:0], strobe.serialBit};
      if (strobe.loadEn)  latchCode <= shiftReg;
    end
  end

  // codes past the last tap clamp to it (33-position ladder only)
  always_comb begin
    if (int'(latchCode) > TOP_TAP) effCode = WORD_W'(TOP_TAP);
    else                           effCode = latchCode;
  end

  for (genvar i = 0; i < NUM_TAPS; i++) begin : gTap
    assign tapSel[i] = shdnN ? (effCode == WORD_W'(i)) : 1'(i == 0);
  end

  assign aSwitchEn   = shdnN;
  assign wiperShortB = ~shdnN;
endmodule

// File: rtl/wiper_pos_ctrl.sv
module wiper_pos_ctrl
  import wiper_pkg::*;
#(
  parameter bit SMALL_LADDER = 1'b0,
  localparam int WORD_W   = wordBits(SMALL_LADDER),
  localparam int NUM_TAPS = tapCount(SMALL_LADDER)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclk,
  input  logic                csN,
  input  logic                sdi,
  input  logic                shdnN,
  output logic [NUM_TAPS-1:0] tapSel,
  output logic                aSwitchEn,
  output logic                wiperShortB
);
  wiperStrobe_t      strobe;
  logic [WORD_W-1:0] latchCode;
  logic              loadPulse;

  assign loadPulse = strobe.loadEn;

  wiper_ctrl uCtrl (
    .clk    (clk),
    .rstN   (rstN),
    .sclk   (sclk),
    .csN    (csN),
    .sdi    (sdi),
    .strobe (strobe)
  );

  wiper_datapath #(.SMALL_LADDER(SMALL_LADDER)) uPath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .shdnN       (shdnN),
    .latchCode   (latchCode),
    .tapSel      (tapSel),
    .aSwitchEn   (aSwitchEn),
    .wiperShortB (wiperShortB)
  );
endmodule

// File: rtl/wiper_pos_checker.sv
module wiper_pos_checker
  import wiper_pkg::*;
#(
  parameter bit SMALL_LADDER = 1'b0,
  localparam int WORD_W   = wordBits(SMALL_LADDER),
  localparam int NUM_TAPS = tapCount(SMALL_LADDER)
) (
  input logic                clk,
  input logic                rstN,
  input logic                shdnN,
  input logic                loadPulse,
  input logic [WORD_W-1:0]   latchCode,
  input logic [NUM_TAPS-1:0] tapSel,
  input logic                aSwitchEn,
  input logic                wiperShortB
);
  assert_one_tap_R5: assert property (@(posedge clk) disable iff (!rstN)
    $countones(tapSel) == 1);

  assert_shutdown_outputs_R7: assert property (@(posedge clk) disable iff (!rstN)
    !shdnN |-> (!aSwitchEn && wiperShortB && tapSel[0]));

  assert_run_outputs_R8: assert property (@(posedge clk) disable iff (!rstN)
    shdnN |-> (aSwitchEn && !wiperShortB));

  assert_latch_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    !loadPulse |=> $stable(latchCode));

  assert_zero_code_R5: assert property (@(posedge clk) disable iff (!rstN)
    (shdnN && latchCode == '0) |-> tapSel[0]);

  if (SMALL_LADDER) begin : gSat
    assert_saturate_R6: assert property (@(posedge clk) disable iff (!rstN)
      (shdnN && int'(latchCode) > 32) |-> tapSel[32]);
  end
endmodule

bind wiper_pos_ctrl wiper_pos_checker #(.SMALL_LADDER(SMALL_LADDER)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .shdnN       (shdnN),
  .loadPulse   (loadPulse),
  .latchCode   (latchCode),
  .tapSel      (tapSel),
  .aSwitchEn   (aSwitchEn),
  .wiperShortB (wiperShortB)
);

// File: tb/tb_wiper_pos_ctrl.sv
`timescale 1ns/1ps
module tb_wiper_pos_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0;
  logic csN = 1'b1;
  logic sdi = 1'b0;
  logic shdnN = 1'b1;
  logic [255:0] tapBig;
  logic [32:0]  tapSmall;
  logic aBig, shortBig, aSmall, shortSmall;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // bench model
  logic [7:0] mShift = 8'h00;
  logic [7:0] mBig   = 8'h80;
  logic [5:0] mSmall = 6'h10;

  always #4 clk = ~clk;

  wiper_pos_ctrl #(.SMALL_LADDER(1'b0)) dut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .sdi(sdi), .shdnN(shdnN),
    .tapSel(tapBig), .aSwitchEn(aBig), .wiperShortB(shortBig));

  wiper_pos_ctrl #(.SMALL_LADDER(1'b1)) dutSmall (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .sdi(sdi), .shdnN(shdnN),
    .tapSel(tapSmall), .aSwitchEn(aSmall), .wiperShortB(shortSmall));

  function automatic logic [255:0] expBig(logic [7:0] code, logic sd);
    logic [255:0] v = '0;
    if (sd) v[code] = 1'b1; else v[0] = 1'b1;
    return v;
  endfunction

  function automatic logic [32:0] expSmall(logic [5:0] code, logic sd);
    logic [32:0] v = '0;
    int idx = (int'(code) > 32) ? 32 : int'(code);
    if (sd) v[idx] = 1'b1; else v[0] = 1'b1;
    return v;
  endfunction

  task automatic checkAll(string req);
    logic [255:0] eb = expBig(mBig, shdnN);
    logic [32:0]  es = expSmall(mSmall, shdnN);
    checks++;
    if (tapBig !== eb) begin
      errors++;
      $display("FAIL %s big tapSel: actual %h expected %h", req, tapBig, eb);
    end
    checks++;
    if (tapSmall !== es) begin
      errors++;
      $display("FAIL %s small tapSel: actual %h expected %h", req, tapSmall, es);
    end
    checks++;
    if ({aBig, shortBig, aSmall, shortSmall} !== {shdnN, ~shdnN, shdnN, ~shdnN}) begin
      errors++;
      $display("FAIL %s switches: actual %b expected %b", req,
               {aBig, shortBig, aSmall, shortSmall}, {shdnN, ~shdnN, shdnN, ~shdnN});
    end
  endtask

  task automatic waitClk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendFrame(int nBits, logic [15:0] bits);
    csN = 1'b0;
    waitClk(6);
    for (int i = nBits - 1; i >= 0; i--) begin
      sdi = bits[i];
      waitClk(4);
      sclk = 1'b1;
      mShift = {mShift[6:0], bits[i]};
      waitClk(4);
      sclk = 1'b0;
    end
    waitClk(6);
    csN = 1'b1;
    mBig = mShift;
    mSmall = mShift[5:0];
    waitClk(8);
  endtask

  task automatic idleClocks(int n);
    for (int i = 0; i < n; i++) begin
      sdi = ~sdi;
      waitClk(4);
      sclk = 1'b1;
      waitClk(4);
      sclk = 1'b0;
    end
    waitClk(8);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    waitClk(3);
    rstN = 1'b1;
    waitClk(4);
    checkAll("R1 R10 reset midscale");

    sendFrame(8, 16'h00);
    checkAll("R5 code zero at B end");
    sendFrame(8, 16'h01);
    checkAll("R2 R5 code one");
    sendFrame(8, 16'hFF);
    checkAll("R6 full code");
    sendFrame(8, 16'h21);
    checkAll("R6 code 33 saturates");
    sendFrame(8, 16'h20);
    checkAll("R6 code 32 top tap");
    sendFrame(8, 16'h1F);
    checkAll("R2 code 31");

    sendFrame(8, 16'hA5);
    idleClocks(3);
    checkAll("R3 clocks with select high");
    sendFrame(5, 16'h0C);
    checkAll("R3 R4 short frame after idle clocks");
    sendFrame(12, 16'h9E3);
    checkAll("R4 long frame");

    sendFrame(8, 16'h5A);
    shdnN = 1'b0;
    #1;
    checkAll("R7 shutdown immediate");
    waitClk(5);
    checkAll("R7 shutdown held");
    shdnN = 1'b1;
    #1;
    checkAll("R8 restore after shutdown");

    shdnN = 1'b0;
    waitClk(2);
    sendFrame(8, 16'h3C);
    checkAll("R9 write during shutdown hidden");
    shdnN = 1'b1;
    #1;
    checkAll("R9 new code after release");

    for (int k = 0; k < 60; k++) begin
      int len = 1 + int'($urandom_range(11));
      logic [15:0] d = 16'($urandom);
      if ($urandom_range(3) == 0) shdnN = ~shdnN;
      #1;
      if ($urandom_range(4) == 0) idleClocks(1 + int'($urandom_range(2)));
      sendFrame(len, d);
      checkAll("R2 R4 R6 R7 random frame");
    end
    shdnN = 1'b1;
    #1;
    checkAll("R8 final release");

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule